// File: doc/BRIEF.md
# Handshake-Paced Command Slave

This block is a byte-serial command and response slave. A host reaches it through an 8-bit handshake port and a shift register. The host drives a request line on the port, and the block answers on an acknowledge line in the same port. Each byte crosses only when the host completes a request/acknowledge exchange. The block takes a command byte first, then an optional in-band length byte, then argument bytes. It passes the command and its arguments to an external dispatcher and latches the reply. It then returns an optional size byte followed by the reply bytes.

A small parameter ROM gives each command its argument length and its response length. A table value of 8'hFF means the length travels in-band as a byte. A command that is not in the table takes no arguments and has an in-band response length.

The engine checks the shift direction on every byte and emits a one-cycle shift-complete pulse for each byte it accepts. It holds a poll-inhibit output high from the moment a command arrives until its last response byte has gone out.

Top module: `hs_cmd_engine`

## Requirements
- R1: After reset, port_q reads 8'h18 (acknowledge bit 3 and request bit 4 both high). sr_irq, poll_hold, disp_valid and sr_out are all low.
- R2: A port write whose value equals the current port_q leaves port_q unchanged and moves no byte.
- R3: A changed port write with bit 4 set and bit 3 clear is stored with bit 3 forced high. No byte moves.
- R4: A changed port write with bit 3 set and bit 4 clear moves one byte. The write is stored with bit 3 cleared, and if the byte is accepted, sr_irq pulses high for exactly one cycle.
- R5: A changed port write with bits 3 and 4 equal is stored as written, moves no byte and starts no command.
- R6: When idle, an accepted byte is the command. It raises poll_hold and looks up both lengths in the table. A command missing from the table has argument length 0 and an in-band response length.
- R7: With an in-band argument length, the first byte after the command is the count of argument bytes that follow.
- R8: A byte moved in the wrong direction is dropped with no sr_irq pulse. While idle or receiving, sr_dir_out must be 1; while responding it must be 0. A dropped byte changes neither the stored arguments nor sr_out.
- R9: Once the argument count is reached, disp_valid pulses for one cycle. During that pulse, disp_cmd, disp_argc and disp_args (byte i at bits 8i+7:8i) show the command.
- R10: With an in-band response length, the first byte returned is the reply size, followed by that many reply bytes.
- R11: With a fixed response length N, exactly N bytes are returned. Positions at or past the dispatcher's size read as 8'h00.
- R12: If the dispatcher does not recognise a command (disp_known low), a fixed length N returns N zero bytes, and an in-band length returns a single size byte of 0.
- R13: After the last response byte, or directly after dispatch when the response length is 0, the engine returns to idle and drops poll_hold. disp_valid is only ever high while poll_hold is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_wr_en | input | 1 | Host write strobe for the handshake port |
| port_wr_data | input | 8 | Value the host writes to the port |
| port_q | output | 8 | Current port value, including the acknowledge bit |
| sr_dir_out | input | 1 | Shift direction: 1 = host to block, 0 = block to host |
| sr_in | input | 8 | Byte the host has shifted in |
| sr_out | output | 8 | Byte the block presents for the host to shift out |
| sr_irq | output | 1 | One-cycle shift-complete pulse |
| poll_hold | output | 1 | High while a command is in progress |
| disp_valid | output | 1 | One-cycle dispatch strobe |
| disp_cmd | output | 8 | Command byte being dispatched |
| disp_argc | output | 8 | Number of stored argument bytes |
| disp_args | output | BUF_CAP*8 | Stored argument bytes |
| disp_known | input | 1 | Dispatcher recognises disp_cmd |
| disp_size | input | 8 | Reply size from the dispatcher |
| disp_data | input | BUF_CAP*8 | Reply bytes from the dispatcher |

## Verification
The assertions watch the port decode on every cycle. They check that an unchanged write is inert, that a request-only write lifts the acknowledge bit, and that writes with both lines equal are stored without a transfer. They also check that sr_irq and disp_valid are single-cycle pulses, and that dispatch happens only while poll_hold is high.

Some properties only the bench scenarios can show: the byte order of in-band length and size bytes, argument and response contents, zero fill for fixed lengths and unknown commands, table-miss defaults, and that wrong-direction bytes leave the stored arguments and the outgoing byte untouched.

// File: rtl/hs_cmd_engine_pkg.sv
package hs_cmd_engine_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_DISP = 2'd2,
    ST_RESP = 2'd3
  } hs_state_e;

  localparam logic [7:0] LEN_INBAND = 8'hFF;
endpackage

// File: rtl/hs_port_decode.sv
module hs_port_decode #(
  parameter int ACK_BIT = 3,
  parameter int REQ_BIT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] port_q,
  output logic       xfer
);
  localparam logic [7:0] ACK_MASK = 8'(1 << ACK_BIT);
  localparam logic [7:0] REQ_MASK = 8'(1 << REQ_BIT);
  localparam logic [7:0] RST_VAL  = ACK_MASK | REQ_MASK;

  logic [7:0] port_d;
  logic       changed;
  logic       port_en;

  always_comb begin
    changed = wr_en && (wr_data != port_q);
    port_en = changed;
    port_d  = port_q;
    xfer    = 1'b0;
    if (changed) begin
      unique case ({wr_data[REQ_BIT], wr_data[ACK_BIT]})
        2'b10: port_d = wr_data | ACK_MASK;
        2'b01: begin
          port_d = wr_data & ~ACK_MASK;
          xfer   = 1'b1;
        end
        default: port_d = wr_data;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= RST_VAL;
    end else if (port_en) begin
      port_q <= port_d;
    end
  end
endmodule

// File: rtl/hs_len_rom.sv
module hs_len_rom
  import hs_cmd_engine_pkg::*;
#(
  parameter int             ROM_N   = 5,
  parameter logic [ROM_N*8-1:0] TBL_CMD = 40'h50_40_30_20_10,
  parameter logic [ROM_N*8-1:0] TBL_ARG = 40'h01_02_00_FF_01,
  parameter logic [ROM_N*8-1:0] TBL_RSP = 40'h03_FF_02_FF_00
) (
  input  logic [7:0] cmd,
  output logic [7:0] arg_len,
  output logic [7:0] rsp_len
);
  logic [ROM_N-1:0] hit;

  for (genvar g = 0; g < ROM_N; g++) begin : g_match
    assign hit[g] = (TBL_CMD[g*8 +: 8] == cmd);
  end

  always_comb begin
    arg_len = 8'h00;
    rsp_len = LEN_INBAND;
    for (int i = 0; i < ROM_N; i++) begin
      if (hit[i]) begin
        arg_len = TBL_ARG[i*8 +: 8];
        rsp_len = TBL_RSP[i*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/hs_cmd_seq.sv
module hs_cmd_seq
  import hs_cmd_engine_pkg::*;
#(
  parameter int BUF_CAP = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 xfer,
  input  logic                 dir_out,
  input  logic [7:0]           sr_in,
  input  logic [7:0]           rom_arg,
  input  logic [7:0]           rom_rsp,
  input  logic                 disp_known,
  input  logic [7:0]           disp_size,
  input  logic [BUF_CAP*8-1:0] disp_data,
  output logic [7:0]           sr_out,
  output logic                 sr_irq,
  output logic                 poll_hold,
  output logic                 disp_valid,
  output logic [7:0]           disp_cmd,
  output logic [7:0]           disp_argc,
  output logic [BUF_CAP*8-1:0] disp_args
);
  localparam int         IDX_W = (BUF_CAP > 1) ? $clog2(BUF_CAP) : 1;
  localparam logic [7:0] CAP_B = 8'(BUF_CAP);

  hs_state_e                   state_q, state_d;
  logic [7:0]                  cmd_q, cmd_d;
  logic [7:0]                  alen_q, alen_d;
  logic                        alen_ok_q, alen_ok_d;
  logic [7:0]                  rlen_q, rlen_d;
  logic                        rlen_ok_q, rlen_ok_d;
  logic [7:0]                  apos_q, apos_d;
  logic [7:0]                  rpos_q, rpos_d;
  logic [7:0]                  rsize_q, rsize_d;
  logic                        hold_q, hold_d;
  logic                        irq_q, irq_d;
  logic [7:0]                  out_q, out_d;
  logic [BUF_CAP-1:0][7:0]     arg_q, arg_d;
  logic [BUF_CAP-1:0][7:0]     rsp_q, rsp_d;
  logic [7:0]                  next_byte;
  logic                        arg_done;
  logic                        rsp_done;

  always_comb begin
    next_byte = 8'h00;
    if ((rpos_q < rsize_q) && (rpos_q < CAP_B)) begin
      next_byte = rsp_q[rpos_q[IDX_W-1:0]];
    end
  end

  assign arg_done = alen_ok_q && (apos_q == alen_q);
  assign rsp_done = rlen_ok_q && (rpos_q == rlen_q);

  always_comb begin
    state_d   = state_q;
    cmd_d     = cmd_q;
    alen_d    = alen_q;
    alen_ok_d = alen_ok_q;
    rlen_d    = rlen_q;
    rlen_ok_d = rlen_ok_q;
    apos_d    = apos_q;
    rpos_d    = rpos_q;
    rsize_d   = rsize_q;
    hold_d    = hold_q;
    irq_d     = 1'b0;
    out_d     = out_q;
    arg_d     = arg_q;
    rsp_d     = rsp_q;
    unique case (state_q)
      ST_IDLE: begin
        if (xfer && dir_out) begin
          cmd_d     = sr_in;
          alen_d    = rom_arg;
          alen_ok_d = (rom_arg != LEN_INBAND);
          rlen_d    = rom_rsp;
          rlen_ok_d = (rom_rsp != LEN_INBAND);
          apos_d    = 8'h00;
          rpos_d    = 8'h00;
          hold_d    = 1'b1;
          irq_d     = 1'b1;
          state_d   = ST_RECV;
        end
      end
      ST_RECV: begin
        if (xfer) begin
          if (dir_out) begin
            irq_d = 1'b1;
            if (!alen_ok_q) begin
              alen_d    = sr_in;
              alen_ok_d = 1'b1;
            end else if (apos_q < CAP_B) begin
              arg_d[apos_q[IDX_W-1:0]] = sr_in;
              apos_d = apos_q + 8'd1;
            end
          end
        end else if (arg_done) begin
          state_d = ST_DISP;
        end
      end
      ST_DISP: begin
        state_d = ST_RESP;
        if (disp_known) begin
          rsize_d = disp_size;
          rsp_d   = disp_data;
        end else begin
          rsize_d = rlen_ok_q ? rlen_q : 8'h00;
          rsp_d   = '0;
        end
      end
      ST_RESP: begin
        if (xfer) begin
          if (!dir_out) begin
            irq_d = 1'b1;
            if (!rlen_ok_q) begin
              out_d     = rsize_q;
              rlen_d    = rsize_q;
              rlen_ok_d = 1'b1;
            end else if (rpos_q < rlen_q) begin
              out_d  = next_byte;
              rpos_d = rpos_q + 8'd1;
            end
          end
        end else if (rsp_done) begin
          state_d = ST_IDLE;
          hold_d  = 1'b0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cmd_q     <= 8'h00;
      alen_q    <= 8'h00;
      alen_ok_q <= 1'b0;
      rlen_q    <= 8'h00;
      rlen_ok_q <= 1'b0;
      apos_q    <= 8'h00;
      rpos_q    <= 8'h00;
      rsize_q   <= 8'h00;
      hold_q    <= 1'b0;
      irq_q     <= 1'b0;
      out_q     <= 8'h00;
      arg_q     <= '0;
      rsp_q     <= '0;
    end else begin
      state_q   <= state_d;
      cmd_q     <= cmd_d;
      alen_q    <= alen_d;
      alen_ok_q <= alen_ok_d;
      rlen_q    <= rlen_d;
      rlen_ok_q <= rlen_ok_d;
      apos_q    <= apos_d;
      rpos_q    <= rpos_d;
      rsize_q   <= rsize_d;
      hold_q    <= hold_d;
      irq_q     <= irq_d;
      out_q     <= out_d;
      arg_q     <= arg_d;
      rsp_q     <= rsp_d;
    end
  end

  assign sr_out     = out_q;
  assign sr_irq     = irq_q;
  assign poll_hold  = hold_q;
  assign disp_valid = (state_q == ST_DISP);
  assign disp_cmd   = cmd_q;
  assign disp_argc  = apos_q;
  assign disp_args  = arg_q;
endmodule

// File: rtl/hs_cmd_engine.sv
module hs_cmd_engine #(
  parameter int                 BUF_CAP = 4,
  parameter int                 ACK_BIT = 3,
  parameter int                 REQ_BIT = 4,
  parameter int                 ROM_N   = 5,
  parameter logic [ROM_N*8-1:0] TBL_CMD = 40'h50_40_30_20_10,
  parameter logic [ROM_N*8-1:0] TBL_ARG = 40'h01_02_00_FF_01,
  parameter logic [ROM_N*8-1:0] TBL_RSP = 40'h03_FF_02_FF_00
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 port_wr_en,
  input  logic [7:0]           port_wr_data,
  output logic [7:0]           port_q,
  input  logic                 sr_dir_out,
  input  logic [7:0]           sr_in,
  output logic [7:0]           sr_out,
  output logic                 sr_irq,
  output logic                 poll_hold,
  output logic                 disp_valid,
  output logic [7:0]           disp_cmd,
  output logic [7:0]           disp_argc,
  output logic [BUF_CAP*8-1:0] disp_args,
  input  logic                 disp_known,
  input  logic [7:0]           disp_size,
  input  logic [BUF_CAP*8-1:0] disp_data
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       xfer;
  logic [7:0] rom_arg;
  logic [7:0] rom_rsp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  hs_port_decode #(
    .ACK_BIT(ACK_BIT),
    .REQ_BIT(REQ_BIT)
  ) u_port (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (port_wr_en),
    .wr_data (port_wr_data),
    .port_q  (port_q),
    .xfer    (xfer)
  );

  hs_len_rom #(
    .ROM_N   (ROM_N),
    .TBL_CMD (TBL_CMD),
    .TBL_ARG (TBL_ARG),
    .TBL_RSP (TBL_RSP)
  ) u_rom (
    .cmd     (sr_in),
    .arg_len (rom_arg),
    .rsp_len (rom_rsp)
  );

  hs_cmd_seq #(
    .BUF_CAP(BUF_CAP)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .xfer       (xfer),
    .dir_out    (sr_dir_out),
    .sr_in      (sr_in),
    .rom_arg    (rom_arg),
    .rom_rsp    (rom_rsp),
    .disp_known (disp_known),
    .disp_size  (disp_size),
    .disp_data  (disp_data),
    .sr_out     (sr_out),
    .sr_irq     (sr_irq),
    .poll_hold  (poll_hold),
    .disp_valid (disp_valid),
    .disp_cmd   (disp_cmd),
    .disp_argc  (disp_argc),
    .disp_args  (disp_args)
  );
endmodule

// File: rtl/hs_cmd_engine_chk.sv
module hs_cmd_engine_chk #(
  parameter int ACK_BIT = 3,
  parameter int REQ_BIT = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       port_wr_en,
  input logic [7:0] port_wr_data,
  input logic [7:0] port_q,
  input logic       sr_irq,
  input logic       poll_hold,
  input logic       disp_valid
);
  logic wr_changed;
  assign wr_changed = port_wr_en && (port_wr_data != port_q);

  assert_nochange_inert_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr_en && (port_wr_data == port_q)) |=> ($stable(port_q) && !sr_irq));

  assert_req_lifts_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_changed && port_wr_data[REQ_BIT] && !port_wr_data[ACK_BIT])
      |=> (port_q[ACK_BIT] && !sr_irq));

  assert_irq_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sr_irq |=> !sr_irq);

  assert_equal_lines_stored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_changed && (port_wr_data[REQ_BIT] == port_wr_data[ACK_BIT]))
      |=> ((port_q == $past(port_wr_data)) && !sr_irq));

  assert_disp_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> !disp_valid);

  assert_disp_under_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> poll_hold);
endmodule

bind hs_cmd_engine hs_cmd_engine_chk #(
  .ACK_BIT(ACK_BIT),
  .REQ_BIT(REQ_BIT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .port_wr_en   (port_wr_en),
  .port_wr_data (port_wr_data),
  .port_q       (port_q),
  .sr_irq       (sr_irq),
  .poll_hold    (poll_hold),
  .disp_valid   (disp_valid)
);

// File: tb/hs_cmd_engine_tb_top.sv
module hs_cmd_engine_tb_top;
  localparam int CAP = 4;

  logic           clk;
  logic           rst_n;
  logic           port_wr_en;
  logic [7:0]     port_wr_data;
  logic [7:0]     port_q;
  logic           sr_dir_out;
  logic [7:0]     sr_in;
  logic [7:0]     sr_out;
  logic           sr_irq;
  logic           poll_hold;
  logic           disp_valid;
  logic [7:0]     disp_cmd;
  logic [7:0]     disp_argc;
  logic [CAP*8-1:0] disp_args;
  logic           disp_known;
  logic [7:0]     disp_size;
  logic [CAP*8-1:0] disp_data;

  int n_chk;
  int n_bad;
  int n_disp;
  logic [7:0]       cap_cmd;
  logic [7:0]       cap_argc;
  logic [CAP*8-1:0] cap_args;
  logic [7:0]       rd_buf [0:7];
  logic             last_irq;
  bit               done;

  hs_cmd_engine dut_i (
    .clk(clk), .rst_n(rst_n),
    .port_wr_en(port_wr_en), .port_wr_data(port_wr_data), .port_q(port_q),
    .sr_dir_out(sr_dir_out), .sr_in(sr_in), .sr_out(sr_out), .sr_irq(sr_irq),
    .poll_hold(poll_hold), .disp_valid(disp_valid), .disp_cmd(disp_cmd),
    .disp_argc(disp_argc), .disp_args(disp_args), .disp_known(disp_known),
    .disp_size(disp_size), .disp_data(disp_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Dispatcher model: size = argc+1, byte i = arg^5A below argc, C3 above.
  always_comb begin
    disp_known = (disp_cmd != 8'h30) && (disp_cmd != 8'h77);
    disp_size  = disp_argc + 8'd1;
    for (int i = 0; i < CAP; i++) begin
      disp_data[i*8 +: 8] = (8'(i) < disp_argc) ? (disp_args[i*8 +: 8] ^ 8'h5A) : 8'hC3;
    end
  end

  always @(negedge clk) begin
    if (disp_valid) begin
      n_disp   <= n_disp + 1;
      cap_cmd  <= disp_cmd;
      cap_argc <= disp_argc;
      cap_args <= disp_args;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hs_wr(input logic [7:0] v);
    @(negedge clk);
    port_wr_en   = 1'b1;
    port_wr_data = v;
    @(negedge clk);
    port_wr_en   = 1'b0;
  endtask

  task automatic move_byte(input logic dir, input logic [7:0] b);
    sr_dir_out = dir;
    sr_in      = b;
    hs_wr(8'h10);
    hs_wr(8'h08);
    last_irq = sr_irq;
    repeat (3) @(negedge clk);
  endtask

  // Sends command, optional in-band length, args; reads nrd bytes.
  task automatic do_cmd(input logic [7:0] c, input int inb, input int na,
                        input logic [31:0] args, input int nrd, input string req);
    int irq_miss;
    irq_miss = 0;
    move_byte(1'b1, c);
    if (!last_irq) irq_miss++;
    if (inb >= 0) begin
      move_byte(1'b1, 8'(inb));
      if (!last_irq) irq_miss++;
    end
    for (int i = 0; i < na; i++) begin
      move_byte(1'b1, args[i*8 +: 8]);
      if (!last_irq) irq_miss++;
    end
    repeat (3) @(negedge clk);
    for (int i = 0; i < nrd; i++) begin
      move_byte(1'b0, 8'h00);
      if (!last_irq) irq_miss++;
      rd_buf[i] = sr_out;
    end
    repeat (3) @(negedge clk);
    check({req, " R4 irq per byte"}, irq_miss, 0);
  endtask

  initial begin
    done = 1'b0;
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; n_disp = 0;
    port_wr_en = 1'b0; port_wr_data = 8'h00;
    sr_dir_out = 1'b1; sr_in = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 port", port_q, 8'h18);
    check("R1 irq", sr_irq, 0);
    check("R1 hold", poll_hold, 0);
    check("R1 disp", disp_valid, 0);
    check("R1 sr_out", sr_out, 8'h00);

    // R3 request-only write lifts acknowledge
    sr_dir_out = 1'b1; sr_in = 8'h20;
    hs_wr(8'h10);
    check("R3 port", port_q, 8'h18);
    check("R3 irq", sr_irq, 0);
    // R2 same value again: inert
    hs_wr(8'h18);
    check("R2 port", port_q, 8'h18);
    check("R2 irq", sr_irq, 0);
    // R5 both low then both high
    hs_wr(8'h00);
    check("R5 low port", port_q, 8'h00);
    check("R5 low irq", sr_irq, 0);
    hs_wr(8'h18);
    check("R5 high port", port_q, 8'h18);
    check("R5 high irq", sr_irq, 0);
    repeat (2) @(negedge clk);
    check("R5 no command", poll_hold, 0);

    // R4 acknowledge-only write moves a byte; R8 wrong direction in idle
    move_byte(1'b0, 8'h20);
    check("R8 idle wrong dir irq", last_irq, 0);
    check("R8 idle wrong dir hold", poll_hold, 0);
    check("R4 port after xfer", port_q, 8'h00);

    // R6 command raises hold; R7/R10 in-band sweep over lengths 0..3
    for (int L = 0; L <= 3; L++) begin
      logic [31:0] a;
      int d0;
      for (int i = 0; i < 4; i++) a[i*8 +: 8] = 8'(8'h11 * (i + 1) + L);
      d0 = n_disp;
      sr_dir_out = 1'b1; sr_in = 8'h20;
      move_byte(1'b1, 8'h20);
      check("R6 hold after command", poll_hold, 1);
      check("R4 command irq", last_irq, 1);
      move_byte(1'b1, 8'(L));
      for (int i = 0; i < L; i++) move_byte(1'b1, a[i*8 +: 8]);
      repeat (3) @(negedge clk);
      check("R9 one dispatch", n_disp - d0, 1);
      check("R9 cmd", cap_cmd, 8'h20);
      check("R7 argc", cap_argc, 8'(L));
      for (int i = 0; i < L; i++) check("R7 arg", cap_args[i*8 +: 8], a[i*8 +: 8]);
      for (int i = 0; i < L + 2; i++) begin
        move_byte(1'b0, 8'h00);
        rd_buf[i] = sr_out;
      end
      repeat (3) @(negedge clk);
      check("R10 size byte", rd_buf[0], 8'(L + 1));
      for (int i = 0; i < L; i++) check("R10 data", rd_buf[i+1], a[i*8 +: 8] ^ 8'h5A);
      check("R10 tail", rd_buf[L+1], 8'hC3);
      check("R13 hold released", poll_hold, 0);
    end

    // R8 wrong direction while receiving and responding (cmd 40: 2 args, in-band rsp)
    move_byte(1'b1, 8'h40);
    move_byte(1'b1, 8'h9A);
    move_byte(1'b0, 8'hEE);
    check("R8 recv wrong dir irq", last_irq, 0);
    move_byte(1'b1, 8'h6B);
    repeat (3) @(negedge clk);
    check("R8 args kept", cap_args[15:0], 16'h6B9A);
    check("R8 argc", cap_argc, 8'd2);
    move_byte(1'b0, 8'h00);
    check("R10 size 3", sr_out, 8'd3);
    move_byte(1'b1, 8'h55);
    check("R8 resp wrong dir irq", last_irq, 0);
    check("R8 sr_out kept", sr_out, 8'd3);
    move_byte(1'b0, 8'h00); rd_buf[0] = sr_out;
    move_byte(1'b0, 8'h00); rd_buf[1] = sr_out;
    move_byte(1'b0, 8'h00); rd_buf[2] = sr_out;
    repeat (3) @(negedge clk);
    check("R10 b0", rd_buf[0], 8'h9A ^ 8'h5A);
    check("R10 b1", rd_buf[1], 8'h6B ^ 8'h5A);
    check("R10 b2", rd_buf[2], 8'hC3);
    check("R13 hold after 40", poll_hold, 0);

    // R13 fixed zero-length response: idle right after dispatch
    do_cmd(8'h10, -1, 1, 32'h0000_00F0, 0, "cmd10");
    check("R9 cmd10", cap_cmd, 8'h10);
    check("R9 cmd10 arg", cap_args[7:0], 8'hF0);
    check("R13 cmd10 hold", poll_hold, 0);

    // R11 fixed length 3 with dispatcher size 2
    do_cmd(8'h50, -1, 1, 32'h0000_0024, 3, "cmd50");
    check("R11 b0", rd_buf[0], 8'h24 ^ 8'h5A);
    check("R11 b1", rd_buf[1], 8'hC3);
    check("R11 b2 zero", rd_buf[2], 8'h00);
    check("R11 hold", poll_hold, 0);

    // R12 unknown with fixed length 2
    do_cmd(8'h30, -1, 0, 32'h0, 2, "cmd30");
    check("R12 fixed b0", rd_buf[0], 8'h00);
    check("R12 fixed b1", rd_buf[1], 8'h00);
    check("R12 fixed hold", poll_hold, 0);

    // R6/R12 table miss: no args, in-band size 0
    do_cmd(8'h77, -1, 0, 32'h0, 1, "cmd77");
    check("R6 miss dispatched", cap_cmd, 8'h77);
    check("R6 miss argc", cap_argc, 8'd0);
    check("R12 in-band size 0", rd_buf[0], 8'h00);
    check("R13 miss hold", poll_hold, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule